// File: doc/BRIEF.md
# Extended Byte and Word Arithmetic Unit

This execution unit performs the extended arithmetic operations of an 8-bit processor core. On the byte side it offers a signed (sign-preserving) right shift and a two's-complement negation of the accumulator. On the word side it offers 16-bit read-modify-write operations on a memory word: increment, decrement, shift left and rotate left through carry. Each operation returns its result together with fresh negative, zero and carry flags.

The surrounding sequencer drives the unit through one byte-wide data port. A byte operation takes its operand in the same cycle as `start`, and the result appears one cycle later. A word operation takes the low byte with `start` and the high byte in the following cycle, and the result appears one cycle after the high byte. The carry flag is sampled together with `start`.

Top module: `xalu_unit`

## Requirements
- R1: Opcode 0 (sign-preserving right shift) gives result[7:0] = {d[7], d[7:1]} and C = d[0]. The `done` output is high in the cycle after `start`.
- R2: Opcode 1 (negate) gives result[7:0] = (256 - d) mod 256, and C equals the sampled carry input. 0x80 negates to 0x80 with N set, and 0x00 negates to 0x00 with Z set.
- R3: Opcode 2 (word increment) gives result = ({hi,lo} + 1) mod 65536, with the carry passed from the low byte into the high byte. C equals the sampled carry input.
- R4: Opcode 3 (word decrement) gives result = ({hi,lo} - 1) mod 65536, with the borrow passed from the low byte into the high byte. C equals the sampled carry input.
- R5: Opcode 4 (word shift left) gives result = {hi,lo} << 1 with bit 0 cleared, and C = old bit 15.
- R6: Opcode 5 (word rotate left) gives result = {w[14:0], carry input} and C = old bit 15.
- R7: For byte operations, N = result bit 7, Z is set only when result[7:0] is zero, and result[15:8] is zero. For word operations, N = result bit 15 and Z is set only when all 16 bits are zero.
- R8: For a word operation, the low byte goes on `dataIn` with `start` and the high byte goes on `dataIn` in the next cycle. `done` is low in that high-byte cycle and high in the cycle after it. A `start` during the high-byte cycle is ignored.
- R9: Opcodes 6 and 7 are ignored: `done` stays low, and result and flags keep their values.
- R10: After reset, `done`, `result`, N, Z and C are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation |
| opSel | input | 3 | Operation code (0 to 5 valid) |
| dataIn | input | 8 | Byte operand, or the low byte and then the high byte of a word |
| carryIn | input | 1 | Carry flag, sampled with start |
| done | output | 1 | Result and flags valid in this cycle |
| result | output | 16 | Operation result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |

## Verification
The hardest case to reach is a carry or borrow that runs across the byte boundary of a word held in two separately captured bytes. It matters most where it wraps the whole word to zero or to 0xFFFF. The bench sweeps every high byte against the low bytes 0x00, 0x01, 0x7F, 0x80, 0xFE and 0xFF with both carry values, so every crossing and both wraps occur. A second hard case is a `start` that arrives while the unit waits for the high byte. The bench deliberately drives a competing `start` in that cycle and then checks that the word result holds and that no extra `done` follows.

// File: rtl/xalu_pkg.sv
package xalu_pkg;
  typedef enum logic [2:0] {
    OP_ASR = 3'd0,
    OP_NEG = 3'd1,
    OP_INW = 3'd2,
    OP_DEW = 3'd3,
    OP_ASW = 3'd4,
    OP_ROW = 3'd5
  } xop_e;

  typedef struct packed {
    logic captureLo;
    logic execByte;
    logic execWord;
  } xstrobe_t;
endpackage

// File: rtl/xalu_ctrl.sv
module xalu_ctrl
  import xalu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opSel,
  output xstrobe_t   strobe,
  output logic       waitHi
);
  always_comb begin
    strobe = '0;
    if (waitHi) begin
      strobe.execWord = 1'b1;
    end else if (start) begin
      case (opSel)
        OP_ASR, OP_NEG: strobe.execByte = 1'b1;
        OP_INW, OP_DEW, OP_ASW, OP_ROW: strobe.captureLo = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitHi <= 1'b0;
    else       waitHi <= strobe.captureLo;
  end

  assert_word_two_beats_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitHi |=> !waitHi);
  assert_no_launch_in_hi_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitHi |-> (!strobe.execByte && !strobe.captureLo));
  assert_bad_op_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!waitHi && start && opSel > 3'd5) |=> !waitHi);
endmodule

// File: rtl/xalu_datapath.sv
module xalu_datapath
  import xalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xstrobe_t              strobe,
  input  logic [2:0]            opSel,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic                  carryIn,
  output logic                  done,
  output logic [2*DATA_W-1:0]   result,
  output logic                  flagN,
  output logic                  flagZ,
  output logic                  flagC
);
  localparam int WORD_W = 2 * DATA_W;

  xop_e              opReg;
  logic [DATA_W-1:0] loReg;
  logic              cReg;

  xop_e              curOp;
  logic              curC;
  logic [WORD_W-1:0] wordV;
  logic [DATA_W-1:0] byteRes;
  logic [WORD_W-1:0] nextRes;
  logic              nextC;
  logic              exec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= OP_ASR;
      loReg <= '0;
      cReg  <= 1'b0;
    end else if (strobe.captureLo) begin
      opReg <= xop_e'(opSel);
      loReg <= dataIn;
      cReg  <= carryIn;
    end
  end

  assign exec  = strobe.execByte | strobe.execWord;
  assign curOp = strobe.execWord ? opReg : xop_e'(opSel);
  assign curC  = strobe.execWord ? cReg : carryIn;
  assign wordV = {dataIn, loReg};

  always_comb begin
    byteRes = '0;
    nextRes = '0;
    nextC   = curC;
    case (curOp)
      OP_ASR: begin
        byteRes = {dataIn[DATA_W-1], dataIn[DATA_W-1:1]};
        nextC   = dataIn[0];
        nextRes = {{DATA_W{1'b0}}, byteRes};
      end
      OP_NEG: begin
        byteRes = ~dataIn + 1'b1;
        nextRes = {{DATA_W{1'b0}}, byteRes};
      end
      OP_INW: nextRes = wordV + 1'b1;
      OP_DEW: nextRes = wordV - 1'b1;
      OP_ASW: begin
        nextRes = {wordV[WORD_W-2:0], 1'b0};
        nextC   = wordV[WORD_W-1];
      end
      OP_ROW: begin
        nextRes = {wordV[WORD_W-2:0], curC};
        nextC   = wordV[WORD_W-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done   <= 1'b0;
      result <= '0;
      flagN  <= 1'b0;
      flagZ  <= 1'b0;
      flagC  <= 1'b0;
    end else begin
      done <= exec;
      if (exec) begin
        result <= nextRes;
        flagC  <= nextC;
        if (strobe.execWord) begin
          flagN <= nextRes[WORD_W-1];
          flagZ <= (nextRes == '0);
        end else begin
          flagN <= byteRes[DATA_W-1];
          flagZ <= (byteRes == '0);
        end
      end
    end
  end

  assert_asr_sign_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.execByte && opSel == OP_ASR) |=>
      (result[DATA_W-1] == $past(dataIn[DATA_W-1]) && flagC == $past(dataIn[0])));
  assert_neg_sum_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.execByte && opSel == OP_NEG) |=>
      (DATA_W'(result[DATA_W-1:0] + $past(dataIn)) == '0));
  assert_incdec_keep_c_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.execWord && (opReg == OP_INW || opReg == OP_DEW)) |=> flagC == $past(cReg));
  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.execByte |=> result[WORD_W-1:DATA_W] == '0);
  assert_done_follows_exec_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(exec));
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !exec |=> $stable(result));
endmodule

// File: rtl/xalu_unit.sv
module xalu_unit
  import xalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          opSel,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic                carryIn,
  output logic                done,
  output logic [2*DATA_W-1:0] result,
  output logic                flagN,
  output logic                flagZ,
  output logic                flagC
);
  xstrobe_t strobe;
  logic     waitHi;

  xalu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .strobe(strobe), .waitHi(waitHi)
  );

  xalu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSel(opSel),
    .dataIn(dataIn), .carryIn(carryIn), .done(done), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC)
  );
endmodule

// File: tb/xalu_unit_test.sv
module xalu_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [7:0]  dataIn = 8'd0;
  logic        carryIn = 1'b0;
  logic        done;
  logic [15:0] result;
  logic        flagN, flagZ, flagC;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  xalu_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .dataIn(dataIn),
    .carryIn(carryIn), .done(done), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected {result[15:0], N, Z, C}
  function automatic logic [18:0] model(int op, int lo, int hi, int cin);
    int w, r, c, n, z;
    w = hi * 256 + lo;
    c = cin;
    r = 0;
    case (op)
      0: begin r = (lo / 2) + ((lo >= 128) ? 128 : 0); c = lo % 2; end
      1: r = (256 - lo) % 256;
      2: r = (w + 1) % 65536;
      3: r = (w + 65535) % 65536;
      4: begin r = (w * 2) % 65536; c = w / 32768; end
      5: begin r = (w * 2) % 65536 + cin; c = w / 32768; end
      default: ;
    endcase
    if (op < 2) begin n = r / 128; z = (r == 0); end
    else        begin n = r / 32768; z = (r == 0); end
    return {r[15:0], n[0], z[0], c[0]};
  endfunction

  task automatic check(string req, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runByte(int op, int v, int cin, string req);
    @(negedge clk);
    start = 1'b1; opSel = op[2:0]; dataIn = v[7:0]; carryIn = cin[0];
    @(negedge clk);
    start = 1'b0;
    check(req, {result, flagN, flagZ, flagC}, model(op, v, 0, cin));
    check("R1 done", {18'd0, done}, 19'd1);
  endtask

  task automatic runWord(int op, int lo, int hi, int cin, bit intrude, string req);
    @(negedge clk);
    start = 1'b1; opSel = op[2:0]; dataIn = lo[7:0]; carryIn = cin[0];
    @(negedge clk);
    if (intrude) begin
      check("R8 done low in high-byte cycle", {18'd0, done}, 19'd0);
      start = 1'b1; opSel = 3'd0; carryIn = ~cin[0];
    end else start = 1'b0;
    dataIn = hi[7:0];
    @(negedge clk);
    start = 1'b0;
    check(req, {result, flagN, flagZ, flagC}, model(op, lo, hi, cin));
    if (intrude) check("R8 done", {18'd0, done}, 19'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int loSet[6];
    logic [18:0] held;
    loSet = '{0, 1, 127, 128, 254, 255};
    repeat (3) @(negedge clk);
    check("R10 reset", {result, flagN, flagZ, flagC}, 19'd0);
    check("R10 reset done", {18'd0, done}, 19'd0);
    rstN = 1'b1;

    for (int v = 0; v < 256; v++) runByte(0, v, v % 2, "R1 asr");
    for (int v = 0; v < 256; v++) runByte(1, v, (v / 2) % 2, "R2 neg R7");
    runByte(1, 128, 0, "R2 neg 0x80");
    runByte(1, 0, 1, "R2 neg 0x00");

    for (int h = 0; h < 256; h++)
      for (int i = 0; i < 6; i++)
        for (int c = 0; c < 2; c++) begin
          runWord(2, loSet[i], h, c, 1'b0, "R3 inw R7");
          runWord(3, loSet[i], h, c, 1'b0, "R4 dew R7");
          runWord(4, loSet[i], h, c, 1'b0, "R5 asw R7");
          runWord(5, loSet[i], h, c, 1'b0, "R6 row R7");
        end

    runWord(2, 255, 255, 0, 1'b1, "R8 intrude inw");
    runWord(5, 1, 128, 1, 1'b1, "R8 intrude row");
    @(negedge clk);
    check("R8 no extra done", {18'd0, done}, 19'd0);

    runWord(3, 0, 0, 1, 1'b0, "R4 dew wrap");
    held = {result, flagN, flagZ, flagC};
    for (int op = 6; op < 8; op++) begin
      @(negedge clk);
      start = 1'b1; opSel = op[2:0]; dataIn = 8'h00; carryIn = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check("R9 done low", {18'd0, done}, 19'd0);
      @(negedge clk);
      check("R9 hold", {result, flagN, flagZ, flagC}, held);
      check("R9 done still low", {18'd0, done}, 19'd0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule